// File: doc/BRIEF.md
# Frame Playback Buffer Sequencer

This block replays one stored downlink frame, a byte at a time, from a frame RAM with three parallel byte lanes: in-phase data, quadrature data and a control lane. Every strobe presents one triplet of bytes. An address counter walks through the RAM. The control lane carries marker bits that end the frame and restart the counter. Other marker bits move the output over to three lane FIFOs for the closing part of each frame. A host refills those FIFOs once per frame, so the header at the end of the frame can change from one frame to the next while the rest of the frame stays fixed.

The host owns the RAM through a takeover port. While the port is held, playback stops, the RAM address comes from the host, and writes and read-backs go straight to the frame store. The frame-end pulse doubles as the host's per-frame service request. A sticky flag records any byte that had to be emitted while the FIFOs were empty.

Top module: `fps_frame_sequencer`

## Requirements
- R1: After synchronous reset the block is in this state: `out_valid`, `frame_end` and `fifo_underflow` are 0, `fifo_level` is 0, the output lanes are 0, and the first strobe reads RAM address 0.
- R2: Each strobe taken outside host takeover produces one triplet with `out_valid` high for exactly one cycle, in the cycle after the strobe edge. The address advances by one after every byte, and it wraps from the last RAM address to 0.
- R3: Bit 3 of a control byte is the terminal flag, from either source. The byte that carries it comes out with `frame_end` high, and the next strobe reads RAM address 0 with RAM as the source.
- R4: With `hdr_en` high, a RAM-sourced byte whose control bit 1 is 1 and bit 2 is 0 makes the following bytes come from the FIFOs in push order. The address counter keeps advancing while the FIFOs are the source.
- R5: While the FIFOs are the source, a byte whose control bit 2 is 1 makes the next byte come from RAM at the advanced address.
- R6: With `hdr_en` low, control bit 1 has no effect and every frame repeats the RAM contents.
- R7: A strobe that finds the FIFOs empty while they are selected outputs an all-zero triplet and sets `fifo_underflow`. The flag stays set until `underflow_clr` is high with no new underflow in the same cycle.
- R8: Each lane FIFO holds 64 triplets. A push while full is dropped, and `fifo_level` shows the number of stored triplets.
- R9: While `host_mode` is high, strobes are ignored and `out_valid` stays low. `host_we` writes `host_wdata` (I in bits 23:16, Q in 15:8, control in 7:0) at `host_addr`, and `host_rdata` shows the previous content of `host_addr` one cycle later. `host_we` has no effect outside host mode. After the takeover, playback restarts at RAM address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_en | input | 1 | Allows the switch to the FIFOs |
| strobe | input | 1 | Requests the next byte triplet |
| host_mode | input | 1 | Host takes over the RAM address |
| host_we | input | 1 | RAM write during takeover |
| host_addr | input | ADDR_W | RAM address during takeover |
| host_wdata | input | 24 | RAM write triplet {I,Q,control} |
| host_rdata | output | 24 | Registered RAM read-back |
| fifo_push | input | 1 | Push one triplet into the FIFOs |
| fifo_wdata | input | 24 | FIFO triplet {I,Q,control} |
| underflow_clr | input | 1 | Clears the sticky underflow flag |
| out_valid | output | 1 | Output triplet valid |
| out_i | output | 8 | In-phase lane byte |
| out_q | output | 8 | Quadrature lane byte |
| out_ctl | output | 8 | Control lane byte (bit 0 parity) |
| frame_end | output | 1 | Terminal-flag byte / per-frame request |
| fifo_underflow | output | 1 | Sticky empty-read flag |
| fifo_level | output | LVL_W | Triplets held in the FIFOs |

## Verification
The assertions check several invariants on every cycle. A terminal flag always returns the counter to address 0 with RAM selected. The FIFOs are never chosen while `hdr_en` is low. The three lane FIFOs keep equal occupancy. Full and empty FIFOs drop their operations. The underflow flag holds, and no byte comes out during takeover. Only the bench scenarios show that the right bytes appear in the right order: the 30th byte handing over to the FIFOs, an early return to RAM part-way through the FIFO section, a long frame ended from the FIFOs, address wrap, and read-back of host writes.

// File: rtl/fps_pkg.sv
package fps_pkg;
    localparam int LANE_W  = 8;
    localparam int N_LANES = 3;
    localparam int WORD_W  = LANE_W * N_LANES;

    // control lane bit positions
    localparam int CTL_PAR  = 0;
    localparam int CTL_GOF  = 1;  // go to FIFO
    localparam int CTL_GOR  = 2;  // go back to RAM
    localparam int CTL_LAST = 3;  // terminal flag

    typedef struct packed {
        logic [LANE_W-1:0] i;
        logic [LANE_W-1:0] q;
        logic [LANE_W-1:0] ctl;
    } lane_word_t;

    typedef enum logic {SRC_RAM = 1'b0, SRC_FIFO = 1'b1} src_t;

    function automatic logic is_last(input logic [LANE_W-1:0] c);
        return c[CTL_LAST];
    endfunction

    function automatic logic wants_fifo(input logic [LANE_W-1:0] c);
        return c[CTL_GOF] && !c[CTL_GOR];
    endfunction

    function automatic logic wants_ram(input logic [LANE_W-1:0] c);
        return c[CTL_GOR];
    endfunction
endpackage

// File: rtl/fps_frame_ram.sv
module fps_frame_ram
    import fps_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  lane_word_t        wdata,
    output lane_word_t        rdata
);
    lane_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/fps_lane_fifo.sv
module fps_lane_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8: a push into a full FIFO leaves the occupancy unchanged
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> $stable(count));

    // R7: a pop from an empty FIFO leaves the occupancy unchanged
    assert_no_underrun_R7: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> $stable(count));
endmodule

// File: rtl/fps_src_ctrl.sv
module fps_src_ctrl
    import fps_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_mode,
    input  logic              strobe,
    input  logic              hdr_en,
    input  logic [LANE_W-1:0] cur_ctl,
    input  logic              fifo_empty,
    output logic [ADDR_W-1:0] addr,
    output src_t              src,
    output logic              take,
    output logic              pop
);
    assign take = strobe && !host_mode;
    assign pop  = take && (src == SRC_FIFO) && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst || host_mode) begin
            addr <= '0;
            src  <= SRC_RAM;
        end else if (take) begin
            if (is_last(cur_ctl)) begin
                addr <= '0;
                src  <= SRC_RAM;
            end else begin
                addr <= addr + 1'b1;
                if (src == SRC_RAM && hdr_en && wants_fifo(cur_ctl))
                    src <= SRC_FIFO;
                else if (src == SRC_FIFO && wants_ram(cur_ctl))
                    src <= SRC_RAM;
            end
        end
    end

    // R3: a terminal flag always restarts at address 0 from RAM
    assert_end_restarts_R3: assert property (@(posedge clk) disable iff (rst)
        (take && is_last(cur_ctl)) |=> (addr == '0 && src == SRC_RAM));

    // R6: with the header enable low the FIFOs are never entered
    assert_ram_only_when_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        (!hdr_en && src == SRC_RAM) |=> (src == SRC_RAM));
endmodule

// File: rtl/fps_frame_sequencer.sv
module fps_frame_sequencer
    import fps_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 64,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_en,
    input  logic              strobe,
    input  logic              host_mode,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              fifo_push,
    input  logic [WORD_W-1:0] fifo_wdata,
    input  logic              underflow_clr,
    output logic              out_valid,
    output logic [LANE_W-1:0] out_i,
    output logic [LANE_W-1:0] out_q,
    output logic [LANE_W-1:0] out_ctl,
    output logic              frame_end,
    output logic              fifo_underflow,
    output logic [LVL_W-1:0]  fifo_level
);
    logic [ADDR_W-1:0] play_addr, ram_addr;
    src_t              src;
    logic              take, pop, starve;
    lane_word_t        ram_word, fifo_word, sel_word, host_word;

    logic [LANE_W-1:0] lane_in   [N_LANES];
    logic [LANE_W-1:0] lane_head [N_LANES];
    logic              lane_empty[N_LANES];
    logic              lane_full [N_LANES];
    logic [LVL_W-1:0]  lane_cnt  [N_LANES];

    assign host_word = host_wdata;
    assign ram_addr  = host_mode ? host_addr : play_addr;

    fps_frame_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (host_mode && host_we),
        .addr  (ram_addr),
        .wdata (host_word),
        .rdata (ram_word)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lane_in[g] = fifo_wdata[WORD_W-1-g*LANE_W -: LANE_W];
        fps_lane_fifo #(.W(LANE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (fifo_push),
            .wdata (lane_in[g]),
            .pop   (pop),
            .head  (lane_head[g]),
            .empty (lane_empty[g]),
            .full  (lane_full[g]),
            .count (lane_cnt[g])
        );
    end

    assign fifo_word = {lane_head[0], lane_head[1], lane_head[2]};
    assign starve    = (src == SRC_FIFO) && lane_empty[0];
    assign sel_word  = (src == SRC_FIFO) ? (starve ? '0 : fifo_word) : ram_word;

    fps_src_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .host_mode  (host_mode),
        .strobe     (strobe),
        .hdr_en     (hdr_en),
        .cur_ctl    (sel_word.ctl),
        .fifo_empty (lane_empty[0]),
        .addr       (play_addr),
        .src        (src),
        .take       (take),
        .pop        (pop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_i          <= '0;
            out_q          <= '0;
            out_ctl        <= '0;
            frame_end      <= 1'b0;
            fifo_underflow <= 1'b0;
            host_rdata     <= '0;
        end else begin
            out_valid      <= take;
            frame_end      <= take && is_last(sel_word.ctl);
            fifo_underflow <= (fifo_underflow && !underflow_clr) || (take && starve);
            if (take) begin
                out_i   <= sel_word.i;
                out_q   <= sel_word.q;
                out_ctl <= sel_word.ctl;
            end
            if (host_mode) host_rdata <= ram_word;
        end
    end

    assign fifo_level = lane_cnt[0];

    // R8: the three lane FIFOs move in lock step
    assert_lanes_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        (lane_cnt[0] == lane_cnt[1]) && (lane_cnt[1] == lane_cnt[2]) &&
        (lane_full[0] == lane_full[2]) && (lane_empty[1] == lane_empty[2]));

    // R9: no byte leaves the block during a host takeover
    assert_host_silent_R9: assert property (@(posedge clk) disable iff (rst)
        host_mode |=> !out_valid);

    // R7: the underflow flag holds until cleared
    assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (fifo_underflow && !underflow_clr) |=> fifo_underflow);

    // R3: a frame end is always carried by a valid byte
    assert_end_with_byte_R3: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> out_valid);
endmodule

// File: tb/fps_frame_sequencer_test.sv
module fps_frame_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hdr_en = 1'b0, strobe = 1'b0, host_mode = 1'b0, host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [23:0] host_wdata = '0, host_rdata, fifo_wdata = '0;
    logic        fifo_push = 1'b0, underflow_clr = 1'b0;
    logic        out_valid, frame_end, fifo_underflow;
    logic [7:0]  out_i, out_q, out_ctl;
    logic [6:0]  fifo_level;

    always #5 clk = ~clk;

    fps_frame_sequencer uut (
        .clk(clk), .rst(rst), .hdr_en(hdr_en), .strobe(strobe),
        .host_mode(host_mode), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .underflow_clr(underflow_clr),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_ctl(out_ctl),
        .frame_end(frame_end), .fifo_underflow(fifo_underflow), .fifo_level(fifo_level)
    );

    int checks = 0, errors = 0;

    // behavioural reference
    logic [23:0] mram [256];
    logic [23:0] mq [$];
    int          m_addr = 0;
    bit          m_src = 0, m_valid = 0, m_end = 0, m_uf = 0;
    logic [23:0] m_out = '0, m_rd = '0;

    function automatic logic [23:0] frame_byte(input int k);
        logic [7:0] i, q, c;
        i = 8'(k * 7 + 3);
        q = ~8'(k * 5);
        c = {7'b0, ^{i, q}};
        if (k == 29) c[1] = 1'b1;
        if (k == 39) c[3] = 1'b1;
        return {i, q, c};
    endfunction

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic st, input logic hm, input logic we, input logic [7:0] ha,
                        input logic [23:0] hw, input logic ps, input logic [23:0] pw,
                        input logic clr, input string req);
        logic [23:0] w;
        bit full_now, nuf;
        strobe = st; host_mode = hm; host_we = we; host_addr = ha; host_wdata = hw;
        fifo_push = ps; fifo_wdata = pw; underflow_clr = clr;
        full_now = (mq.size() >= 64);
        nuf = m_uf && !clr;
        if (hm) begin
            m_rd = mram[ha];
            if (we) mram[ha] = hw;
            m_valid = 0; m_end = 0; m_addr = 0; m_src = 0;
        end else if (st) begin
            if (m_src) begin
                if (mq.size() > 0) w = mq.pop_front();
                else begin w = '0; nuf = 1; end
            end else w = mram[m_addr];
            m_out = w; m_valid = 1; m_end = w[3];
            if (w[3]) begin m_addr = 0; m_src = 0; end
            else begin
                m_addr = (m_addr + 1) % 256;
                if (!m_src && hdr_en && w[1] && !w[2]) m_src = 1;
                else if (m_src && w[2]) m_src = 0;
            end
        end else begin
            m_valid = 0; m_end = 0;
        end
        m_uf = nuf;
        if (ps && !full_now) mq.push_back(pw);
        @(posedge clk);
        @(negedge clk);
        cmp(req, "out_valid", 32'(out_valid), 32'(m_valid));
        cmp(req, "out_word", {8'h0, out_i, out_q, out_ctl}, {8'h0, m_out});
        cmp(req, "frame_end", 32'(frame_end), 32'(m_end));
        cmp(req, "underflow", 32'(fifo_underflow), 32'(m_uf));
        cmp(req, "level", 32'(fifo_level), 32'(mq.size()));
        cmp(req, "host_rdata", {8'h0, host_rdata}, {8'h0, m_rd});
    endtask

    task automatic play(input int n, input string req);
        for (int k = 0; k < n; k++) step(1, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic takeover(input string req);
        step(0, 1, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic push_words(input int n, input int gor_at, input int last_at, input string req);
        for (int j = 0; j < n; j++) begin
            logic [7:0] c = '0;
            if (j == gor_at)  c[2] = 1'b1;
            if (j == last_at) c[3] = 1'b1;
            step(0, 0, 0, 0, 0, 1, {8'(8'hA0 + j), 8'(8'h50 + j), c}, 0, req);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) mram[a] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R9: fill the frame store during takeover, then read back
        for (int a = 0; a < 256; a++) step(0, 1, 1, 8'(a), frame_byte(a), 0, 0, 0, "R9");
        step(0, 1, 0, 8'd7, 0, 0, 0, 0, "R9");
        step(0, 1, 0, 8'd39, 0, 0, 0, 0, "R9");
        step(0, 0, 1, 8'd5, 24'hABCDEF, 0, 0, 0, "R9");   // write outside takeover ignored
        step(0, 1, 0, 8'd5, 0, 0, 0, 0, "R9");
        step(0, 1, 0, 8'd5, 0, 0, 0, 0, "R9");
        step(1, 1, 0, 8'd0, 0, 0, 0, 0, "R9");            // strobe ignored
        // R6, R3, R2: header enable low, frames repeat from RAM
        hdr_en = 1'b0;
        play(90, "R6");
        for (int k = 0; k < 30; k++) step(k[0], 0, 0, 0, 0, 0, 0, 0, "R2");
        takeover("R9");
        play(12, "R9");
        takeover("R9");
        // R4: header section from the FIFOs, frame ended by the FIFO terminal flag
        hdr_en = 1'b1;
        push_words(10, -1, 9, "R8");
        play(40, "R4");
        play(5, "R3");
        // R7: FIFO starves after the switch
        play(40, "R7");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
        takeover("R7");
        // R5: early return to RAM
        push_words(5, 4, -1, "R5");
        play(45, "R5");
        takeover("R5");
        // R3: long frame from the spare FIFO entries
        push_words(20, -1, 19, "R3");
        play(55, "R3");
        takeover("R3");
        // R8: fill past the depth, then drain with concurrent pushes
        push_words(70, -1, -1, "R8");
        for (int k = 0; k < 40; k++) step(1, 0, 0, 0, 0, 1, 24'h123400, 0, "R8");
        play(80, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R7");
        takeover("R8");
        // R2: no terminal flag, run across the address wrap
        hdr_en = 1'b0;
        step(0, 1, 1, 8'd39, 24'h0F0F00, 0, 0, 0, "R2");
        takeover("R2");
        play(300, "R2");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule